// File: doc/BRIEF.md
# Page Load Buffer with Inactivity Timeout

This block gathers single-byte writes into a page-sized staging buffer and remembers which page they belong to. Each granted byte load restarts an idle counter. When no further byte arrives within a set number of clock ticks, loading is over. The block then runs a commit of fixed length that copies the whole page into a storage array it models itself. Every byte position that was not loaded in this round is written as FFh, so old contents of that page are not kept.

A separate request clears the entire array to FFh during a second commit of fixed length. A command decoder upstream gives the grant signal, which qualifies both write strobes and erase requests. While a commit or erase is running, the block reports busy and drops any strobe it receives. Reads come straight from the array with one cycle of latency.

The low seven address bits select the byte within a page. The remaining upper bits select the page. The address width is a parameter: the full part uses 17 bits (1024 pages), and the default here is 11 bits (16 pages).

Top module: `page_load_buffer`

## Requirements
- R1: After reset, `busy` is 0, `last_addr` is 0 and `last_data` is 0.
- R2: Address bits [6:0] are the byte offset and the bits above them are the page number. A commit writes every loaded byte at its offset inside the page of the last byte accepted, even when earlier bytes named another page.
- R3: Loading the same offset again before the commit replaces the earlier value. Only the last value is committed.
- R4: `busy` rises exactly LOAD_TIMEOUT clock edges after the edge that accepted the last byte. A byte accepted on any edge up to and including that one keeps loading open and restarts the count.
- R5: A commit holds `busy` high for exactly COMMIT_TICKS cycles and cannot be cut short.
- R6: At commit, every offset of the target page that was not loaded since the previous commit is written as FFh. A load of 1 up to 128 bytes is accepted.
- R7: An `erase_req` with `wr_grant` while idle holds `busy` high for exactly ERASE_TICKS cycles and leaves every array byte at FFh.
- R8: A write strobe that arrives while `busy` is high is ignored. It does not change `last_addr`, `last_data` or the array, and it does not start a later commit.
- R9: A write strobe without `wr_grant` is ignored. It changes no output and starts no commit.
- R10: With `rd_en` high, `rd_data` shows the array byte at `rd_addr` one clock later. Pages other than the committed page keep their contents.
- R11: `last_addr` and `last_data` show the address and data of the most recently accepted byte load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Byte-load strobe, one cycle per byte |
| wr_grant | input | 1 | Grant from the command decoder; qualifies strobes and erase |
| wr_addr | input | ADDR_W | Byte-load address (page in the upper bits, offset in [6:0]) |
| wr_data | input | 8 | Byte-load data |
| erase_req | input | 1 | Request to clear the whole array to FFh |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, one cycle after `rd_en` |
| busy | output | 1 | High during a commit or an erase |
| last_addr | output | ADDR_W | Address of the last accepted byte load |
| last_data | output | 8 | Data of the last accepted byte load |

## Verification
A wrong idle count or a wrong commit length shows on `busy` at once. The rising or falling edge lands one or more cycles away from the expected edge, and the bench measures both edges in cycles. A stale valid mask, a wrong page register or a merge error does not show at a port until the commit has finished. It then appears as a wrong byte when the array is read back. For that reason every commit is followed by a read of the whole array, compared against a bench model. A strobe that should have been dropped shows on `last_addr` on the next cycle, or as a `busy` pulse that appears with no cause about LOAD_TIMEOUT cycles later.

// File: rtl/page_load_pkg.sv
package page_load_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t BLANK = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_COMMIT,
        ST_ERASE
    } plb_state_e;

    function automatic byte_t merge_byte(input logic loaded, input byte_t val);
        return loaded ? val : BLANK;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/plb_page_store.sv
module plb_page_store
    import page_load_pkg::*;
#(
    parameter int OFF_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic             ld_first,
    input  logic [OFF_W-1:0] ld_off,
    input  byte_t            ld_data,
    input  logic [OFF_W-1:0] walk_off,
    output byte_t            walk_data,
    output logic             walk_loaded
);
    localparam int PAGE_BYTES = 1 << OFF_W;

    byte_t                 page_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (ld_en) page_q[ld_off] <= ld_data;
    end

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)
                valid_q[i] <= 1'b0;
            else if (ld_en && ld_first)
                valid_q[i] <= (ld_off == OFF_W'(i));
            else if (ld_en && ld_off == OFF_W'(i))
                valid_q[i] <= 1'b1;
        end
    end

    assign walk_data   = page_q[walk_off];
    assign walk_loaded = valid_q[walk_off];

    AST_BYTE_MARKED: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> valid_q[$past(ld_off)]);                                   // R3
    AST_FRESH_MASK: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ld_first) |=> ($countones(valid_q) == 1));                 // R6

endmodule

// File: rtl/plb_ctrl.sv
module plb_ctrl
    import page_load_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int OFF_W        = 7,
    parameter int LOAD_TIMEOUT = 40,
    parameter int COMMIT_TICKS = 200,
    parameter int ERASE_TICKS  = 2100
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ld_en,
    input  logic [ADDR_W-OFF_W-1:0] ld_page,
    input  logic                   erase_en,
    output logic                   accept,
    output logic                   first,
    output logic                   busy,
    output logic [OFF_W-1:0]       walk_off,
    input  byte_t                  walk_data,
    input  logic                   walk_loaded,
    output logic                   arr_we,
    output logic [ADDR_W-1:0]      arr_waddr,
    output byte_t                  arr_wdata
);
    localparam int PG_W       = ADDR_W - OFF_W;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int TMR_MAX    = max_int(max_int(LOAD_TIMEOUT, COMMIT_TICKS),
                                        max_int(ERASE_TICKS, DEPTH));
    localparam int TMR_W      = $clog2(TMR_MAX + 1);

    plb_state_e        state;
    logic [TMR_W-1:0]  tmr;
    logic [PG_W-1:0]   page;

    assign accept = ld_en && (state == ST_IDLE || state == ST_LOAD);
    assign first  = ld_en && (state == ST_IDLE);
    assign busy   = (state == ST_COMMIT) || (state == ST_ERASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            tmr   <= '0;
            page  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_LOAD;
                        tmr   <= '0;
                        page  <= ld_page;
                    end else if (erase_en) begin
                        state <= ST_ERASE;
                        tmr   <= '0;
                    end
                end
                ST_LOAD: begin
                    if (accept) begin
                        tmr  <= '0;
                        page <= ld_page;
                    end else if (tmr == TMR_W'(LOAD_TIMEOUT - 1)) begin
                        state <= ST_COMMIT;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_COMMIT: begin
                    if (tmr == TMR_W'(COMMIT_TICKS - 1)) begin
                        state <= ST_IDLE;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: begin
                    if (tmr == TMR_W'(ERASE_TICKS - 1)) begin
                        state <= ST_IDLE;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
            endcase
        end
    end

    assign walk_off = tmr[OFF_W-1:0];

    always_comb begin
        arr_we    = 1'b0;
        arr_waddr = tmr[ADDR_W-1:0];
        arr_wdata = BLANK;
        if (state == ST_COMMIT) begin
            arr_we    = (tmr < TMR_W'(PAGE_BYTES));
            arr_waddr = {page, walk_off};
            arr_wdata = merge_byte(walk_loaded, walk_data);
        end else if (state == ST_ERASE) begin
            arr_we    = (tmr < TMR_W'(DEPTH));
        end
    end

    AST_COMMIT_HELD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COMMIT && tmr != TMR_W'(COMMIT_TICKS - 1)) |=> (state == ST_COMMIT)); // R5
    AST_PAGE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(page));                                             // R2

endmodule

// File: rtl/plb_array.sv
module plb_array
    import page_load_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  byte_t             wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output byte_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (re)
            rdata <= mem[raddr];
    end

endmodule

// File: rtl/page_load_buffer.sv
module page_load_buffer
    import page_load_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int OFF_W        = 7,
    parameter int LOAD_TIMEOUT = 40,
    parameter int COMMIT_TICKS = 200,
    parameter int ERASE_TICKS  = 2100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              wr_grant,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              erase_req,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic [ADDR_W-1:0] last_addr,
    output logic [7:0]        last_data
);
    logic             accept, first, arr_we, walk_loaded;
    logic [OFF_W-1:0] walk_off;
    logic [ADDR_W-1:0] arr_waddr;
    byte_t            walk_data, arr_wdata;

    plb_ctrl #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LOAD_TIMEOUT(LOAD_TIMEOUT),
        .COMMIT_TICKS(COMMIT_TICKS), .ERASE_TICKS(ERASE_TICKS)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .ld_en(wr_stb && wr_grant),
        .ld_page(wr_addr[ADDR_W-1:OFF_W]),
        .erase_en(erase_req && wr_grant),
        .accept(accept), .first(first), .busy(busy),
        .walk_off(walk_off), .walk_data(walk_data), .walk_loaded(walk_loaded),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
    );

    plb_page_store #(.OFF_W(OFF_W)) u_store (
        .clk(clk), .rst(rst),
        .ld_en(accept), .ld_first(first),
        .ld_off(wr_addr[OFF_W-1:0]), .ld_data(wr_data),
        .walk_off(walk_off), .walk_data(walk_data), .walk_loaded(walk_loaded)
    );

    plb_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst),
        .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_addr <= '0;
            last_data <= '0;
        end else if (accept) begin
            last_addr <= wr_addr;
            last_data <= wr_data;
        end
    end

    AST_BUSY_DROPS_LOAD: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_stb && wr_grant) |=> ($stable(last_addr) && $stable(last_data))); // R8
    AST_GRANT_NEEDED: assert property (@(posedge clk) disable iff (rst)
        (!wr_grant) |=> $stable(last_addr));                                 // R9

endmodule

// File: tb/page_load_buffer_bench.sv
module page_load_buffer_bench;
    localparam int AW = 11, OW = 7, TO = 40, CT = 200, ET = 2100;
    localparam int PB = 1 << OW, DEPTH = 1 << AW, NPG = DEPTH / PB;

    logic          clk = 1'b0, rst = 1'b1;
    logic          wr_stb = 0, wr_grant = 0, erase_req = 0, rd_en = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0, last_addr;
    logic [7:0]    wr_data = '0, rd_data, last_data;
    logic          busy;

    page_load_buffer u_page_load_buffer (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_grant(wr_grant),
        .wr_addr(wr_addr), .wr_data(wr_data), .erase_req(erase_req),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .last_addr(last_addr), .last_data(last_data)
    );

    always #4 clk = ~clk;

    int   n_chk = 0, n_bad = 0;
    bit   finished = 0;
    logic [7:0] model [DEPTH];
    logic [7:0] pbuf [PB];
    bit   pval [PB];
    bit   pending = 0;
    int   ppage = 0;

    function automatic logic [7:0] exp_byte(bit loaded, logic [7:0] v);
        return loaded ? v : 8'hFF;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // caller sits at a negedge; returns at the negedge after the capturing edge
    task automatic load(int a, int d);
        wr_stb = 1; wr_grant = 1; wr_addr = AW'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_stb = 0; wr_grant = 0;
        if (!pending) begin
            for (int o = 0; o < PB; o++) pval[o] = 0;
            pending = 1;
        end
        pval[a % PB] = 1; pbuf[a % PB] = 8'(d); ppage = a / PB;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_commit(string tag);
        int c = 0;
        while (!busy && c < TO + 10) begin @(negedge clk); c++; end
        chk(c == TO, {tag, " R4 idle cycles before busy"}, c, TO);
        c = 0;
        while (busy && c < CT + 10) begin @(negedge clk); c++; end
        chk(c == CT, {tag, " R5 busy length"}, c, CT);
        for (int o = 0; o < PB; o++)
            model[ppage * PB + o] = exp_byte(pval[o], pbuf[o]);
        pending = 0;
    endtask

    task automatic verify_all(string tag);
        int bad = 0, fa = 0, fe = 0;
        for (int a = 0; a < DEPTH; a++) begin
            rd_en = 1; rd_addr = AW'(a);
            @(negedge clk);
            if (rd_data !== model[a]) begin
                if (bad == 0) begin fa = int'(rd_data); fe = int'(model[a]); end
                bad++;
            end
        end
        rd_en = 0;
        chk(bad == 0, {tag, " array readback"}, fa, fe);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk(busy == 0, "R1 busy after reset", busy, 0);
        chk(last_addr == 0, "R1 last_addr after reset", last_addr, 0);
        chk(last_data == 0, "R1 last_data after reset", last_data, 0);

        // R7 erase
        erase_req = 1; wr_grant = 1;
        @(negedge clk);
        erase_req = 0; wr_grant = 0;
        begin
            int c = 0;
            while (busy && c < ET + 10) begin @(negedge clk); c++; end
            chk(c == ET, "R7 erase busy length", c, ET);
        end
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        verify_all("R7 erase");

        // R3 / R4 / R6 / R11: directed page 5, rewrite, maximal gap
        load(5 * PB + 3, 8'h11);
        idle(TO - 1);
        load(5 * PB + 9, 8'h22);
        load(5 * PB + 3, 8'h33);
        chk(last_addr == AW'(5 * PB + 3), "R11 last_addr", last_addr, 5 * PB + 3);
        chk(last_data == 8'h33, "R11 last_data", last_data, 8'h33);
        chk(busy == 0, "R4 loading still open", busy, 0);
        run_commit("R3 R6 page5");
        verify_all("R3 R6 R10 page5");

        // R2: last byte names another page
        load(2 * PB + 0, 8'hA5);
        load(2 * PB + 127, 8'h5A);
        idle(7);
        load(9 * PB + 64, 8'hC3);
        run_commit("R2 switch");
        verify_all("R2 bytes land in last page");

        // R8: strobe during busy
        load(1 * PB + 1, 8'h01);
        while (!busy) @(negedge clk);
        load(12 * PB + 7, 8'hEE);
        pending = 1; ppage = 1;
        for (int o = 0; o < PB; o++) pval[o] = (o == 1);
        pbuf[1] = 8'h01;
        chk(last_addr == AW'(PB + 1), "R8 last_addr kept", last_addr, PB + 1);
        chk(last_data == 8'h01, "R8 last_data kept", last_data, 8'h01);
        while (busy) @(negedge clk);
        for (int o = 0; o < PB; o++) model[PB + o] = exp_byte(pval[o], pbuf[o]);
        pending = 0;
        idle(TO + 5);
        chk(busy == 0, "R8 no commit from dropped strobe", busy, 0);
        verify_all("R8 array untouched");

        // R9: no grant
        wr_stb = 1; wr_addr = AW'(4 * PB + 4); wr_data = 8'h77;
        @(negedge clk);
        wr_stb = 0;
        chk(last_addr == AW'(PB + 1), "R9 last_addr unchanged", last_addr, PB + 1);
        idle(TO + 5);
        chk(busy == 0, "R9 no commit without grant", busy, 0);

        // R6 full page of 128 bytes
        for (int o = 0; o < PB; o++) load(6 * PB + o, (o * 7 + 1) & 8'hFF);
        run_commit("R6 full page");

        // R2 random page writes
        for (int k = 0; k < 6; k++) begin
            int pg = $urandom_range(0, NPG - 1);
            int n  = $urandom_range(1, 20);
            for (int j = 0; j < n; j++) begin
                load(pg * PB + $urandom_range(0, PB - 1), $urandom_range(0, 255));
                if (j != n - 1) idle($urandom_range(0, TO - 1));
            end
            run_commit("R2 random");
        end
        verify_all("R2 R10 random pages");

        // R7 final erase
        erase_req = 1; wr_grant = 1;
        @(negedge clk);
        erase_req = 0; wr_grant = 0;
        while (busy) @(negedge clk);
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        verify_all("R7 final erase");

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule